// File: doc/BRIEF.md
# DMA Channel Event Interrupt Controller

This block gathers the completion and error events of a group of DMA channels and turns them into one interrupt line. Each channel reports four kinds of event: the end of a whole descriptor chain, the end of a single descriptor node, and two separate error classes. Every event pulse sets a sticky pending bit in a raw register for its class. A per-class enable mask then decides which pending bits may raise the interrupt.

Software reads status through a small register port with address, write strobe, write data and read data. It can see the masked view of each class, or a summary word that merges all enabled classes per channel. It acknowledges events by writing ones to a raw register. The same port also gives a read-only copy of the channel busy flags and a read/write channel priority word. The priority word is only stored here; the channel engines that use it are outside this block.

Top module: `dmairq_ctrl`

## Requirements
- R1: After reset, all four raw registers, all four enable masks and the priority word read zero, and `irq_o` is low.
- R2: A one-cycle high on bit i of an event input sets bit i of that class's raw register at the next clock edge. The bit stays set until software clears it. The raw registers are at 0x600 (chain end), 0x608 (node end), 0x610 (error A) and 0x618 (error B).
- R3: Writing a raw register clears each bit written as 1 and leaves each bit written as 0 unchanged.
- R4: If an event for bit i and a write of 1 to the same raw bit fall in the same cycle, the bit ends up set.
- R5: The masked class registers at 0x04, 0x08, 0x0C and 0x10 (chain end, node end, error A, error B) each read as raw AND enable mask for that class.
- R6: The enable masks at 0x18, 0x1C, 0x20 and 0x24 (same class order) store the low NUM_CH bits of a write, and their upper bits read zero. A 1 enables that channel's events in the class.
- R7: The summary word at 0x00 has bit i set exactly when at least one class has bit i both pending and enabled.
- R8: `irq_o` is high exactly when the summary word is nonzero.
- R9: The word at 0x690 reads the `ch_busy_i` inputs, with bit i for channel i.
- R10: The priority word at 0x688 stores a full-width write and reads it back.
- R11: Writes to the summary, masked, busy or unmapped addresses change no state, and reads of unmapped addresses return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronised inside the block |
| evt_chain_i | input | NUM_CH | Chain-end event pulses, one bit per channel |
| evt_node_i | input | NUM_CH | Node-end event pulses, one bit per channel |
| evt_erra_i | input | NUM_CH | Error class A pulses, one bit per channel |
| evt_errb_i | input | NUM_CH | Error class B pulses, one bit per channel |
| ch_busy_i | input | NUM_CH | Channel running flags |
| reg_addr | input | ADDR_W | Register byte address |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for `reg_addr`, combinational |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The bench builds the block with NUM_CH = 4, so each class has only sixteen mask values and sixteen event patterns. For every class it sweeps all 256 pairs of mask and pending pattern. In each pair it compares the raw, masked and summary reads and the interrupt line against values computed with plain bitwise arithmetic. Separate passes cover partial acknowledge writes, a set and a clear that collide on the same bit, upper mask bits, every busy pattern, and writes aimed at read-only or unmapped addresses.

// File: rtl/dmairq_pkg.sv
package dmairq_pkg;
  localparam int unsigned CLS_N = 4;

  typedef enum logic [1:0] {
    CLS_CHAIN = 2'd0,
    CLS_NODE  = 2'd1,
    CLS_ERRA  = 2'd2,
    CLS_ERRB  = 2'd3
  } evt_class_e;

  localparam logic [11:0] OFS_SUMMARY = 12'h000;
  localparam logic [11:0] OFS_PRIO    = 12'h688;
  localparam logic [11:0] OFS_BUSY    = 12'h690;

  // masked views: 0x04 + 4*class
  function automatic logic [11:0] ofs_masked(input int unsigned c);
    return 12'h004 + 12'(4 * c);
  endfunction

  // enable masks: 0x18 + 4*class
  function automatic logic [11:0] ofs_enable(input int unsigned c);
    return 12'h018 + 12'(4 * c);
  endfunction

  // raw pending: 0x600 + 8*class
  function automatic logic [11:0] ofs_raw(input int unsigned c);
    return 12'h600 + 12'(8 * c);
  endfunction
endpackage

// File: rtl/dmairq_evt_bank.sv
module dmairq_evt_bank #(
  parameter int unsigned NUM_CH = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] evt_i,
  input  logic [NUM_CH-1:0] clr_i,
  output logic [NUM_CH-1:0] raw_o
);
  logic [NUM_CH-1:0] raw_q;
  logic [NUM_CH-1:0] raw_d;
  logic              raw_en;

  // new events override an acknowledge on the same bit
  always_comb begin
    raw_en = (|evt_i) | (|clr_i);
    raw_d  = (raw_q & ~clr_i) | evt_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q <= '0;
    end else if (raw_en) begin
      raw_q <= raw_d;
    end
  end

  assign raw_o = raw_q;

  // R2: an event bit is pending one edge later
  p_evt_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_i != '0) |=> ((raw_q & $past(evt_i)) == $past(evt_i)));

  // R3: an acknowledged bit without a new event is cleared
  p_ack_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr_i & ~evt_i) != '0) |=> ((raw_q & $past(clr_i & ~evt_i)) == '0));

  // R2: pending state holds when nothing touches it
  p_raw_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((evt_i == '0) && (clr_i == '0)) |=> $stable(raw_q));
endmodule

// File: rtl/dmairq_regs.sv
module dmairq_regs
  import dmairq_pkg::*;
#(
  parameter int unsigned NUM_CH = 16,
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 32
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [CLS_N-1:0][NUM_CH-1:0] raw_i,
  input  logic [NUM_CH-1:0]            busy_i,
  input  logic [ADDR_W-1:0]            reg_addr,
  input  logic                         reg_we,
  input  logic [DATA_W-1:0]            reg_wdata,
  output logic [CLS_N-1:0][NUM_CH-1:0] clr_o,
  output logic [NUM_CH-1:0]            summary_o,
  output logic [DATA_W-1:0]            reg_rdata
);
  logic [CLS_N-1:0][NUM_CH-1:0] mask_q;
  logic [CLS_N-1:0][NUM_CH-1:0] mask_d;
  logic [CLS_N-1:0]             mask_en;
  logic [CLS_N-1:0][NUM_CH-1:0] masked;
  logic [DATA_W-1:0]            prio_q;
  logic [DATA_W-1:0]            prio_d;
  logic                         prio_en;

  for (genvar c = 0; c < CLS_N; c++) begin : g_cls
    always_comb begin
      mask_en[c] = reg_we && (reg_addr == ADDR_W'(ofs_enable(c)));
      mask_d[c]  = reg_wdata[NUM_CH-1:0];
      clr_o[c]   = (reg_we && (reg_addr == ADDR_W'(ofs_raw(c))))
                   ? reg_wdata[NUM_CH-1:0] : '0;
      masked[c]  = raw_i[c] & mask_q[c];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mask_q[c] <= '0;
      end else if (mask_en[c]) begin
        mask_q[c] <= mask_d[c];
      end
    end
  end

  always_comb begin
    prio_en = reg_we && (reg_addr == ADDR_W'(OFS_PRIO));
    prio_d  = reg_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prio_q <= '0;
    end else if (prio_en) begin
      prio_q <= prio_d;
    end
  end

  always_comb begin
    summary_o = '0;
    for (int unsigned c = 0; c < CLS_N; c++) begin
      summary_o = summary_o | masked[c];
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == ADDR_W'(OFS_SUMMARY)) reg_rdata = DATA_W'(summary_o);
    if (reg_addr == ADDR_W'(OFS_PRIO))    reg_rdata = prio_q;
    if (reg_addr == ADDR_W'(OFS_BUSY))    reg_rdata = DATA_W'(busy_i);
    for (int unsigned c = 0; c < CLS_N; c++) begin
      if (reg_addr == ADDR_W'(ofs_masked(c))) reg_rdata = DATA_W'(masked[c]);
      if (reg_addr == ADDR_W'(ofs_enable(c))) reg_rdata = DATA_W'(mask_q[c]);
      if (reg_addr == ADDR_W'(ofs_raw(c)))    reg_rdata = DATA_W'(raw_i[c]);
    end
  end

  // R6, R11: masks only move on a write strobe
  p_mask_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_we |=> $stable(mask_q));

  // R10: priority word captures the written value
  p_prio_store_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && (reg_addr == ADDR_W'(OFS_PRIO))) |=> (prio_q == $past(reg_wdata)));
endmodule

// File: rtl/dmairq_ctrl.sv
module dmairq_ctrl
  import dmairq_pkg::*;
#(
  parameter int unsigned NUM_CH = 16,
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] evt_chain_i,
  input  logic [NUM_CH-1:0] evt_node_i,
  input  logic [NUM_CH-1:0] evt_erra_i,
  input  logic [NUM_CH-1:0] evt_errb_i,
  input  logic [NUM_CH-1:0] ch_busy_i,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_we,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq_o
);
  logic [1:0]                   rst_sync_q;
  logic                         rst_int_n;
  logic [CLS_N-1:0][NUM_CH-1:0] evt_all;
  logic [CLS_N-1:0][NUM_CH-1:0] raw_all;
  logic [CLS_N-1:0][NUM_CH-1:0] clr_all;
  logic [NUM_CH-1:0]            summary;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync_q[1];

  always_comb begin
    evt_all[CLS_CHAIN] = evt_chain_i;
    evt_all[CLS_NODE]  = evt_node_i;
    evt_all[CLS_ERRA]  = evt_erra_i;
    evt_all[CLS_ERRB]  = evt_errb_i;
  end

  for (genvar c = 0; c < CLS_N; c++) begin : g_bank
    dmairq_evt_bank #(.NUM_CH(NUM_CH)) u_bank (
      .clk   (clk),
      .rst_n (rst_int_n),
      .evt_i (evt_all[c]),
      .clr_i (clr_all[c]),
      .raw_o (raw_all[c])
    );
  end

  dmairq_regs #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .raw_i     (raw_all),
    .busy_i    (ch_busy_i),
    .reg_addr  (reg_addr),
    .reg_we    (reg_we),
    .reg_wdata (reg_wdata),
    .clr_o     (clr_all),
    .summary_o (summary),
    .reg_rdata (reg_rdata)
  );

  assign irq_o = |summary;

  // R8: interrupt line agrees with the summary word seen on the port
  p_irq_match_r8: assert property (@(posedge clk) disable iff (!rst_int_n)
    (reg_addr == ADDR_W'(OFS_SUMMARY)) |-> (irq_o == (reg_rdata != '0)));
endmodule

// File: tb/tb_dmairq_ctrl.sv
module tb_dmairq_ctrl;
  localparam int unsigned NCH = 4;
  localparam int unsigned AW  = 12;
  localparam int unsigned DW  = 32;

  logic           clk = 1'b0;
  logic           rst_n;
  logic [NCH-1:0] evt_c, evt_n, evt_a, evt_b, busy;
  logic [AW-1:0]  addr;
  logic           we;
  logic [DW-1:0]  wdata;
  logic [DW-1:0]  rdata;
  logic           irq;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  dmairq_ctrl #(.NUM_CH(NCH), .ADDR_W(AW), .DATA_W(DW)) dut (
    .clk(clk), .rst_n(rst_n),
    .evt_chain_i(evt_c), .evt_node_i(evt_n), .evt_erra_i(evt_a), .evt_errb_i(evt_b),
    .ch_busy_i(busy), .reg_addr(addr), .reg_we(we), .reg_wdata(wdata),
    .reg_rdata(rdata), .irq_o(irq)
  );

  function automatic logic [AW-1:0] a_masked(int c); return AW'(12'h004 + 4*c); endfunction
  function automatic logic [AW-1:0] a_en(int c);     return AW'(12'h018 + 4*c); endfunction
  function automatic logic [AW-1:0] a_raw(int c);    return AW'(12'h600 + 8*c); endfunction

  task automatic chk(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd_chk(input logic [AW-1:0] a, input logic [DW-1:0] exp, input string req);
    addr = a;
    #1;
    chk(rdata == exp, req, rdata, exp);
  endtask

  task automatic pulse(input int c, input logic [NCH-1:0] v);
    @(negedge clk);
    case (c)
      0: evt_c = v;
      1: evt_n = v;
      2: evt_a = v;
      default: evt_b = v;
    endcase
    @(negedge clk);
    evt_c = '0; evt_n = '0; evt_a = '0; evt_b = '0;
  endtask

  task automatic clear_all();
    for (int c = 0; c < 4; c++) begin
      wr(a_raw(c), '1);
      wr(a_en(c), '0);
    end
  endtask

  initial begin
    #400000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; evt_c = '0; evt_n = '0; evt_a = '0; evt_b = '0;
    busy = '0; addr = '0; we = 1'b0; wdata = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    for (int c = 0; c < 4; c++) begin
      rd_chk(a_raw(c), '0, "R1 raw");
      rd_chk(a_en(c), '0, "R1 mask");
    end
    rd_chk(AW'(12'h688), '0, "R1 prio");
    chk(irq == 1'b0, "R1 irq", DW'(irq), '0);

    // R10: priority word
    wr(AW'(12'h688), 32'hA5C3_0F19);
    rd_chk(AW'(12'h688), 32'hA5C3_0F19, "R10 prio");
    wr(AW'(12'h688), '0);
    rd_chk(AW'(12'h688), '0, "R10 prio zero");

    // R9: busy sweep
    for (int b = 0; b < 16; b++) begin
      @(negedge clk);
      busy = NCH'(b);
      rd_chk(AW'(12'h690), DW'(b), "R9 busy");
    end
    busy = '0;

    // R2 R5 R7 R8: exhaustive mask x pending per class
    for (int c = 0; c < 4; c++) begin
      for (int m = 0; m < 16; m++) begin
        for (int r = 0; r < 16; r++) begin
          clear_all();
          wr(a_en(c), DW'(m));
          pulse(c, NCH'(r));
          rd_chk(a_raw(c), DW'(r), "R2 raw set");
          rd_chk(a_masked(c), DW'(r & m), "R5 masked");
          rd_chk(AW'(12'h000), DW'(r & m), "R7 summary");
          chk(irq == ((r & m) != 0), "R8 irq", DW'(irq), DW'((r & m) != 0));
        end
      end
    end

    // R7: several classes merge per channel
    clear_all();
    for (int c = 0; c < 4; c++) wr(a_en(c), '1);
    pulse(0, 4'b0001);
    pulse(2, 4'b0100);
    pulse(3, 4'b0001);
    rd_chk(AW'(12'h000), 32'h5, "R7 merge");
    wr(a_en(2), '0);
    rd_chk(AW'(12'h000), 32'h1, "R7 merge masked");

    // R3: partial acknowledge
    clear_all();
    pulse(1, 4'b1111);
    wr(a_raw(1), 32'h5);
    rd_chk(a_raw(1), 32'hA, "R3 partial clear");
    wr(a_raw(1), 32'h0);
    rd_chk(a_raw(1), 32'hA, "R3 zero write");
    repeat (3) @(negedge clk);
    rd_chk(a_raw(1), 32'hA, "R2 sticky");

    // R4: event and clear on same bit in one cycle
    clear_all();
    pulse(3, 4'b0011);
    @(negedge clk);
    addr = a_raw(3); wdata = 32'h3; we = 1'b1; evt_b = 4'b0010;
    @(negedge clk);
    we = 1'b0; evt_b = '0;
    rd_chk(a_raw(3), 32'h2, "R4 set wins");

    // R6: upper mask bits dropped
    wr(a_en(0), 32'hFFFF_FFFF);
    rd_chk(a_en(0), 32'hF, "R6 mask width");

    // R11: writes to read-only and unmapped addresses
    clear_all();
    wr(a_en(1), 32'h9);
    pulse(1, 4'b1001);
    wr(AW'(12'h000), '1);
    wr(a_masked(1), '1);
    wr(AW'(12'h690), '1);
    wr(AW'(12'h604), '1);
    wr(AW'(12'h014), '1);
    rd_chk(a_raw(1), 32'h9, "R11 raw kept");
    rd_chk(a_en(1), 32'h9, "R11 mask kept");
    rd_chk(AW'(12'h688), '0, "R11 prio kept");
    rd_chk(AW'(12'h604), '0, "R11 unmapped read");
    chk(irq == 1'b1, "R11 irq kept", DW'(irq), 1);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule